// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This unit sits beside an I2C protocol engine and turns its single-cycle event strobes into sticky status flags. There are seven event classes: arbitration lost, no-acknowledge, access ready, receive ready, transmit ready, stop condition seen and addressed as target. An enable mask selects which flags may interrupt the host. A single level-sensitive interrupt line is high while any enabled flag is pending.

Software services the line through a vector register. A read of that register returns a small code for the highest-priority enabled pending event. For most event classes, the read also retires the flag it reports. The receive-ready and transmit-ready flags stay set until the data path signals that the data byte was taken or loaded. The status register also shows two live levels that never interrupt: a bus-busy bit, tracked from start and stop detection, and a receive-shift-full bit.

Top module: `i2c_irq_vector`

## Requirements
- R1: After a synchronous active-low reset, the status word, the mask and the vector all read 0, and `irq` is low.
- R2: A pulse on `evt_pulse[k]` sets status bit k at the next clock edge, and the bit stays set until it is cleared. The event bits are: 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop seen, 6 addressed as target.
- R3: The mask register is at offset 0x04. Bits 6:0 are read/write and use the same bit order as the event bits. The upper bits always read 0.
- R4: `irq` is high exactly when some status event bit is set and its mask bit is 1.
- R5: A read at offset 0x28 returns k+1 for the lowest-numbered event k that is both pending and enabled, and 0 when no such event exists.
- R6: A vector read clears the reported flag for events 0, 1, 2, 5 and 6. It leaves event 3 (receive ready) and event 4 (transmit ready) set.
- R7: A pulse on `rx_data_taken` clears event bit 3, and a pulse on `tx_data_loaded` clears event bit 4.
- R8: The status register is at offset 0x08. Writing 1 to bit 0, 1, 2, 5 or 6 clears that flag. Writes to bits 3, 4, 11 and 12 have no effect.
- R9: Status bit 12 (bus busy) is set by `bus_start` and cleared by `bus_stop`; start wins when both pulse in the same cycle. Register writes do not change it, and it never raises `irq`.
- R10: Status bit 11 follows the `shift_full` input level in the same cycle and never raises `irq`.
- R11: When an event pulse coincides with any clear of the same flag, the flag ends up set.
- R12: Masked events still latch in the status register, but they are invisible to the vector and to `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 7 | One-cycle event strobes from the protocol engine |
| rx_data_taken | input | 1 | Receive data byte consumed; clears receive ready |
| tx_data_loaded | input | 1 | Transmit data byte written; clears transmit ready |
| bus_start | input | 1 | Start condition detected on the bus |
| bus_stop | input | 1 | Stop condition detected on the bus |
| shift_full | input | 1 | Receive shift register full (live level) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request, active high |

## Verification
The main sweep tries every combination of the 128 mask values and the 128 pending-event patterns. It checks the vector code, the interrupt line and the status remaining after the vector read. This separates priority order, masking, and which flags a read retires from which it leaves. Single-event patterns show that each code maps to its own bit. Patterns with several bits set show the lowest-code winner. Patterns whose pending bits are all masked show that masked flags latch without interrupting. Directed cases then cover what the sweep cannot see: write-one-to-clear on protected bits, data-path clears, a set that coincides with a clear, and the busy and shift-full levels.

// File: rtl/i2c_irq_pkg.sv
// Package: shared constants for the I2C interrupt vector unit.
// Assumes seven event classes in fixed priority order (index 0 highest).
package i2c_irq_pkg;

    localparam int unsigned N_EVT  = 7;
    localparam int unsigned CODE_W = $clog2(N_EVT + 1);

    // Event indices; the index is both the status/mask bit and code-1.
    typedef enum logic [2:0] {
        EV_ARB_LOST = 3'd0,
        EV_NO_ACK   = 3'd1,
        EV_ACC_RDY  = 3'd2,
        EV_RX_RDY   = 3'd3,
        EV_TX_RDY   = 3'd4,
        EV_STOP_SEEN = 3'd5,
        EV_ADDR_HIT = 3'd6
    } evt_idx_e;

    // Register byte offsets.
    localparam logic [5:0] OFS_MASK = 6'h04;
    localparam logic [5:0] OFS_STAT = 6'h08;
    localparam logic [5:0] OFS_VEC  = 6'h28;

    // Flags retired by a vector read or by write-one-to-clear.
    localparam logic [N_EVT-1:0] SW_CLEARABLE = 7'b110_0111;

    // Live status bit positions.
    localparam int unsigned STAT_SHIFT_FULL = 11;
    localparam int unsigned STAT_BUS_BUSY   = 12;

endpackage

// File: rtl/evt_flag_bank.sv
// Module: bank of sticky event flags.
// Each flag sets on its pulse and clears on its clear request; a set
// in the same cycle as a clear wins. Assumes synchronous active-low reset.
module evt_flag_bank #(
    parameter int unsigned WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flag_o
);

    logic [WIDTH-1:0] flag_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_flag
        // Per-bit sticky flag with set priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[g] <= 1'b0;
            else if (set_i[g])
                flag_q[g] <= 1'b1;
            else if (clr_i[g])
                flag_q[g] <= 1'b0;
        end
    end

    assign flag_o = flag_q;

    // R11: a pulsed flag is set on the following cycle, whatever the clears.
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));

    // R6 R7 R8: a clear without a set leaves the flag low.
    p_clear_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((flag_q & $past(clr_i & ~set_i)) == '0));

endmodule

// File: rtl/irq_prio_enc.sv
// Module: fixed-priority encoder from pending bits to a vector code.
// Bit 0 is the highest priority; the code is index+1, or 0 when idle.
module irq_prio_enc #(
    parameter int unsigned N  = 7,
    parameter int unsigned CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  pend_i,
    output logic [CW-1:0] code_o
);

    // Scan from the lowest priority up so the lowest index is written last.
    always_comb begin
        code_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i])
                code_o = CW'(i + 1);
        end
    end

endmodule

// File: rtl/bus_line_state.sv
// Module: live bus-condition levels for the status word.
// Busy sets on a start and clears on a stop (start wins); shift-full
// is passed through as a level. Assumes synchronous active-low reset.
module bus_line_state (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic shift_full_i,
    output logic busy_o,
    output logic shift_full_o
);

    logic busy_q;

    // Track bus ownership between start and stop conditions.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (start_i)
            busy_q <= 1'b1;
        else if (stop_i)
            busy_q <= 1'b0;
    end

    assign busy_o       = busy_q;
    assign shift_full_o = shift_full_i;

    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_q);

    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !busy_q);

endmodule

// File: rtl/i2c_irq_vector.sv
// Module: I2C interrupt vector and status unit (top).
// Latches event pulses, masks them, encodes the winner into a vector
// register with clear-on-read, and drives one interrupt line.
// Assumes register reads are combinational, with side effects taken at
// the clock edge where reg_rd is high. Synchronous active-low reset.
module i2c_irq_vector
    import i2c_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EVT-1:0]  evt_pulse,
    input  logic              rx_data_taken,
    input  logic              tx_data_loaded,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              shift_full,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(OFS_VEC);

    logic [N_EVT-1:0]  mask_q;
    logic [N_EVT-1:0]  flags;
    logic [N_EVT-1:0]  pend;
    logic [N_EVT-1:0]  clr_req;
    logic [N_EVT-1:0]  clr_w1c;
    logic [N_EVT-1:0]  clr_vec;
    logic [N_EVT-1:0]  clr_data;
    logic [CODE_W-1:0] vec_code;
    logic              busy;
    logic              sfull;
    logic              wr_mask;
    logic              wr_stat;
    logic              rd_vec;

    assign wr_mask = reg_wr && (reg_addr == A_MASK);
    assign wr_stat = reg_wr && (reg_addr == A_STAT);
    assign rd_vec  = reg_rd && (reg_addr == A_VEC);

    // Interrupt enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_mask)
            mask_q <= reg_wdata[N_EVT-1:0];
    end

    // Write-one-to-clear request, limited to software-clearable flags.
    always_comb begin
        clr_w1c = '0;
        if (wr_stat)
            clr_w1c = reg_wdata[N_EVT-1:0] & SW_CLEARABLE;
    end

    // Clear-on-read of the reported event, one-hot from the vector code.
    for (genvar g = 0; g < N_EVT; g++) begin : g_vec_clr
        assign clr_vec[g] = rd_vec && SW_CLEARABLE[g]
                            && (vec_code == CODE_W'(g + 1));
    end

    // Data-path clears for the receive and transmit ready flags.
    always_comb begin
        clr_data            = '0;
        clr_data[EV_RX_RDY] = rx_data_taken;
        clr_data[EV_TX_RDY] = tx_data_loaded;
    end

    assign clr_req = clr_w1c | clr_vec | clr_data;

    evt_flag_bank #(
        .WIDTH (N_EVT)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_pulse),
        .clr_i  (clr_req),
        .flag_o (flags)
    );

    assign pend = flags & mask_q;

    irq_prio_enc #(
        .N  (N_EVT),
        .CW (CODE_W)
    ) u_enc (
        .pend_i (pend),
        .code_o (vec_code)
    );

    bus_line_state u_bus (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (bus_start),
        .stop_i       (bus_stop),
        .shift_full_i (shift_full),
        .busy_o       (busy),
        .shift_full_o (sfull)
    );

    assign irq = |pend;

    // Register readback multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_MASK: reg_rdata[N_EVT-1:0] = mask_q;
            A_STAT: begin
                reg_rdata[N_EVT-1:0]       = flags;
                reg_rdata[STAT_SHIFT_FULL] = sfull;
                reg_rdata[STAT_BUS_BUSY]   = busy;
            end
            A_VEC:  reg_rdata[CODE_W-1:0] = vec_code;
            default: reg_rdata = '0;
        endcase
    end

    // R4 R5: the line and the encoder agree on whether work is pending.
    p_irq_has_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (vec_code != '0));

    // R5: the reported event is pending and enabled.
    p_winner_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code != '0) |-> pend[vec_code - 1'b1]);

    // R5: no higher-priority enabled event is pending.
    p_no_higher_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code != '0) |->
        ((pend & ((N_EVT'(1) << (vec_code - 1'b1)) - N_EVT'(1))) == '0));

    // R3: the mask changes only on a write to its offset.
    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask_q));

endmodule

// File: tb/test_i2c_irq_vector.sv
module test_i2c_irq_vector;

    localparam logic [5:0] A_MASK = 6'h04;
    localparam logic [5:0] A_STAT = 6'h08;
    localparam logic [5:0] A_VEC  = 6'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt_pulse = '0;
    logic        rx_data_taken = 1'b0;
    logic        tx_data_loaded = 1'b0;
    logic        bus_start = 1'b0;
    logic        bus_stop = 1'b0;
    logic        shift_full = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    i2c_irq_vector i_i2c_irq_vector (
        .clk            (clk),
        .rst_n          (rst_n),
        .evt_pulse      (evt_pulse),
        .rx_data_taken  (rx_data_taken),
        .tx_data_loaded (tx_data_loaded),
        .bus_start      (bus_start),
        .bus_stop       (bus_stop),
        .shift_full     (shift_full),
        .reg_wr         (reg_wr),
        .reg_rd         (reg_rd),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .irq            (irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, input string req, input logic [15:0] exp);
        reg_rd = 1'b1; reg_addr = a;
        #1 chk(req, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] p);
        evt_pulse = p;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic clear_all();
        rx_data_taken = 1'b1; tx_data_loaded = 1'b1;
        wr(A_STAT, 16'h0067);
        rx_data_taken = 1'b0; tx_data_loaded = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_STAT, "R1 status", 16'h0000);
        rd(A_MASK, "R1 mask", 16'h0000);
        rd(A_VEC, "R1 vector", 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);

        // R3 mask width and readback
        wr(A_MASK, 16'hFFFF);
        rd(A_MASK, "R3 mask", 16'h007F);
        wr(A_MASK, 16'h0000);

        // R2 persistence of a latched flag
        pulse(7'h40);
        repeat (3) @(negedge clk);
        rd(A_STAT, "R2 persist", 16'h0040);
        clear_all();

        // R8 protected bits, then W1C; R7 data-path clears
        pulse(7'h7F);
        wr(A_STAT, 16'h1818);
        rd(A_STAT, "R8 protected", 16'h007F);
        wr(A_STAT, 16'h0067);
        rd(A_STAT, "R8 w1c", 16'h0018);
        rx_data_taken = 1'b1; @(negedge clk); rx_data_taken = 1'b0;
        rd(A_STAT, "R7 rx clear", 16'h0010);
        tx_data_loaded = 1'b1; @(negedge clk); tx_data_loaded = 1'b0;
        rd(A_STAT, "R7 tx clear", 16'h0000);

        // R11 set wins over W1C and over clear-on-read
        evt_pulse = 7'h04;
        wr(A_STAT, 16'h0004);
        evt_pulse = '0;
        rd(A_STAT, "R11 w1c", 16'h0004);
        clear_all();
        wr(A_MASK, 16'h0001);
        pulse(7'h01);
        evt_pulse = 7'h01;
        rd(A_VEC, "R11 vec code", 16'h0001);
        evt_pulse = '0;
        rd(A_STAT, "R11 vec read", 16'h0001);
        clear_all();

        // R9 bus busy
        wr(A_MASK, 16'h007F);
        bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
        rd(A_STAT, "R9 busy set", 16'h1000);
        chk("R9 irq", {15'd0, irq}, 16'h0000);
        rd(A_VEC, "R9 vector", 16'h0000);
        wr(A_STAT, 16'h1000);
        rd(A_STAT, "R9 write", 16'h1000);
        bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
        rd(A_STAT, "R9 stop", 16'h0000);
        bus_start = 1'b1; bus_stop = 1'b1; @(negedge clk);
        bus_start = 1'b0; bus_stop = 1'b0;
        rd(A_STAT, "R9 start wins", 16'h1000);
        bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;

        // R10 shift-full level
        shift_full = 1'b1;
        rd(A_STAT, "R10 level", 16'h0800);
        chk("R10 irq", {15'd0, irq}, 16'h0000);
        shift_full = 1'b0;
        rd(A_STAT, "R10 drop", 16'h0000);

        // R4 R5 R6 R12 exhaustive mask x pattern sweep
        for (int m = 0; m < 128; m++) begin
            wr(A_MASK, 16'(m));
            for (int p = 0; p < 128; p++) begin
                int code;
                logic [6:0] after;
                code = 0;
                for (int k = 6; k >= 0; k--)
                    if (p[k] && m[k]) code = k + 1;
                after = p[6:0];
                if (code != 0 && code != 4 && code != 5)
                    after[code-1] = 1'b0;
                pulse(p[6:0]);
                chk("R4 irq", {15'd0, irq}, {15'd0, code != 0});
                rd(A_VEC, "R5 vector", 16'(code));
                rd(A_STAT, "R6 R12 status", {9'd0, after});
                clear_all();
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule